// File: doc/BRIEF.md
# Speculative Reorder Buffer

This block tracks in-flight instructions in a speculative out-of-order core, from issue until in-order retirement. When the issue stage allocates an instruction, the buffer claims an entry at its tail and returns that entry's index. The index serves as the destination tag that reservation stations wait on. Functional units broadcast results on a completion bus. The entry whose tag matches captures the value, together with an exception flag and a mispredict flag.

The oldest entry retires once its result is present, and at most one entry retires per cycle. A register-writing entry drives the register-file write port, and a store entry drives the store port. Results that have completed but have not yet retired can be read through operand lookup ports. A completion arriving in the same cycle as a lookup is forwarded straight to that lookup.

Two events flush every younger entry, leave the buffer empty and pulse a flush output for one cycle:
- a branch retiring with its mispredict flag set;
- an entry retiring with its exception flag set.

An exception is signalled only when its entry reaches the head, so exceptions stay precise.

Top module: `spec_rob`

## Requirements
- R1: After reset the buffer is empty, `issue_ready_o` is 1 and `issue_tag_o` is 0. `rf_we_o`, `st_valid_o`, `exc_o`, `flush_o` and every `lookup_ready_o` bit are 0.
- R2: Each accepted issue takes the tail entry and returns its index on `issue_tag_o`. Tags increase by one modulo DEPTH. With DEPTH entries in flight, `issue_ready_o` is 0.
- R3: A completion bus beat (`cdb_valid_i`) whose tag names an occupied entry stores the value and both flags, and marks the entry done.
- R4: Only the head entry retires, only once it is done, in issue order, and at most one per cycle. A retiring entry of kind 0 (register) drives `rf_we_o`=1 with its destination on `rf_addr_o` and its value on `rf_data_o`, in the cycle after its completion beat.
- R5: A retiring entry of kind 1 (store) drives `st_valid_o`=1 with its destination on `st_addr_o` and its value on `st_data_o`. `rf_we_o` stays 0.
- R6: A lookup returns ready=1 and the stored value for an occupied, done entry. It returns ready=0 for an entry that is free or not yet done.
- R7: When a completion beat's tag equals a lookup tag and names an occupied entry, that lookup returns ready=1 with the bus value in the same cycle.
- R8: A retiring entry of kind 2 (branch) with its mispredict flag set writes nothing, raises `flush_o` for exactly one cycle and discards every younger entry. The next issue gets the branch tag plus one. A branch retiring without the flag causes no flush.
- R9: An exception flag on an entry that is not the head raises nothing. When that entry retires, `exc_o` and `flush_o` are 1, the entry writes nothing and all younger entries are discarded.
- R10: `issue_ready_o` is 0 in a flush cycle.
- R11: An issue and a retirement in the same cycle both take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| issue_valid_i | input | 1 | Issue request |
| issue_kind_i | input | 2 | 0 register, 1 store, 2 branch |
| issue_dest_i | input | DEST_W | Register index or store address |
| issue_ready_o | output | 1 | Entry available and no flush |
| issue_tag_o | output | TAG_W | Tag of the entry to be allocated |
| cdb_valid_i | input | 1 | Completion beat |
| cdb_tag_i | input | TAG_W | Tag of the completing entry |
| cdb_value_i | input | DATA_W | Result value |
| cdb_exc_i | input | 1 | Instruction faulted |
| cdb_mispred_i | input | 1 | Branch was mispredicted |
| lookup_tag_i | input | N_LOOK*TAG_W | Operand lookup tags, port k at bits k*TAG_W |
| lookup_ready_o | output | N_LOOK | Lookup value available |
| lookup_value_o | output | N_LOOK*DATA_W | Lookup values |
| rf_we_o | output | 1 | Register file write |
| rf_addr_o | output | DEST_W | Register index |
| rf_data_o | output | DATA_W | Register value |
| st_valid_o | output | 1 | Store retire |
| st_addr_o | output | DEST_W | Store address |
| st_data_o | output | DATA_W | Store data |
| exc_o | output | 1 | Precise exception at head |
| flush_o | output | 1 | Younger entries discarded |

## Verification
The bench makes two functions coincide in a single cycle.

- Completion and lookup: a completion beat and an operand lookup hit the same tag while the entry is still not done. The lookup must already report the bus value in that cycle.
- Issue and retirement: an issue lands in the cycle a full buffer retires its head. The new tag must be the slot just freed, and retirement must continue in order through the remaining entries.

A branch completion is also timed to coincide with the retirement of the entry before it. A wrap-around sweep then checks tags and retired values against arithmetic expectations.

// File: rtl/rob_pkg.sv
package rob_pkg;
  typedef enum logic [1:0] {
    KIND_REG    = 2'd0,
    KIND_STORE  = 2'd1,
    KIND_BRANCH = 2'd2
  } rob_kind_e;
endpackage

// File: rtl/rob_ptr_ctrl.sv
module rob_ptr_ctrl #(
  parameter int DEPTH = 8,
  localparam int TAG_W = $clog2(DEPTH),
  localparam int PW = TAG_W + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_valid_i,
  input  logic             commit_i,
  input  logic             flush_i,
  output logic             issue_ok_o,
  output logic [TAG_W-1:0] head_o,
  output logic [TAG_W-1:0] tail_o
);
  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] head_q, tail_q;
  logic full;

  // extra wrap bit separates full from empty
  assign full       = (head_q[TAG_W-1:0] == tail_q[TAG_W-1:0]) && (head_q[TAG_W] != tail_q[TAG_W]);
  assign issue_ok_o = !full && !flush_i;
  assign head_o     = head_q[TAG_W-1:0];
  assign tail_o     = tail_q[TAG_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      if (commit_i) head_q <= head_q + ONE;
      if (flush_i) tail_q <= head_q + ONE;
      else if (issue_valid_i && issue_ok_o) tail_q <= tail_q + ONE;
    end
  end

  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !commit_i) |=> $stable(tail_q));
  p_head_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_i |=> (head_q == $past(head_q) + ONE));
  p_flush_empty_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> (head_q == tail_q));
endmodule

// File: rtl/rob_entries.sv
module rob_entries
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int N_LOOK = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     alloc_i,
  input  logic [TAG_W-1:0]         tail_i,
  input  rob_kind_e                kind_i,
  input  logic [DEST_W-1:0]        dest_i,
  input  logic                     cdb_valid_i,
  input  logic [TAG_W-1:0]         cdb_tag_i,
  input  logic [DATA_W-1:0]        cdb_value_i,
  input  logic                     cdb_exc_i,
  input  logic                     cdb_mispred_i,
  input  logic [TAG_W-1:0]         head_i,
  input  logic                     commit_i,
  input  logic                     flush_i,
  input  logic [N_LOOK*TAG_W-1:0]  lookup_tag_i,
  output logic [N_LOOK-1:0]        lookup_ready_o,
  output logic [N_LOOK*DATA_W-1:0] lookup_value_o,
  output logic                     head_valid_o,
  output logic                     head_done_o,
  output logic                     head_exc_o,
  output logic                     head_mis_o,
  output rob_kind_e                head_kind_o,
  output logic [DEST_W-1:0]        head_dest_o,
  output logic [DATA_W-1:0]        head_val_o
);
  typedef struct packed {
    logic              valid;
    logic              done;
    logic              exc;
    logic              mis;
    rob_kind_e         kind;
    logic [DEST_W-1:0] dest;
    logic [DATA_W-1:0] val;
  } entry_t;

  entry_t ent_q [DEPTH];
  logic   cdb_hit;

  assign cdb_hit = cdb_valid_i && ent_q[cdb_tag_i].valid;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
    end else begin
      if (cdb_hit) begin
        ent_q[cdb_tag_i].done <= 1'b1;
        ent_q[cdb_tag_i].val  <= cdb_value_i;
        ent_q[cdb_tag_i].exc  <= cdb_exc_i;
        ent_q[cdb_tag_i].mis  <= cdb_mispred_i;
      end
      if (commit_i) ent_q[head_i].valid <= 1'b0;
      if (flush_i) begin
        for (int i = 0; i < DEPTH; i++) ent_q[i].valid <= 1'b0;
      end
      if (alloc_i) begin
        ent_q[tail_i].valid <= 1'b1;
        ent_q[tail_i].done  <= 1'b0;
        ent_q[tail_i].exc   <= 1'b0;
        ent_q[tail_i].mis   <= 1'b0;
        ent_q[tail_i].kind  <= kind_i;
        ent_q[tail_i].dest  <= dest_i;
        ent_q[tail_i].val   <= '0;
      end
    end
  end

  assign head_valid_o = ent_q[head_i].valid;
  assign head_done_o  = ent_q[head_i].done;
  assign head_exc_o   = ent_q[head_i].exc;
  assign head_mis_o   = ent_q[head_i].mis;
  assign head_kind_o  = ent_q[head_i].kind;
  assign head_dest_o  = ent_q[head_i].dest;
  assign head_val_o   = ent_q[head_i].val;

  for (genvar k = 0; k < N_LOOK; k++) begin : g_look
    logic [TAG_W-1:0] tag;
    logic             fwd;
    assign tag = lookup_tag_i[k*TAG_W +: TAG_W];
    // same-cycle completion bypasses the entry
    assign fwd = cdb_hit && (cdb_tag_i == tag);
    assign lookup_ready_o[k] = fwd || (ent_q[tag].valid && ent_q[tag].done);
    assign lookup_value_o[k*DATA_W +: DATA_W] = fwd ? cdb_value_i : ent_q[tag].val;
  end

  p_capture_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cdb_hit && !flush_i && !(commit_i && head_i == cdb_tag_i) && !(alloc_i && tail_i == cdb_tag_i))
    |=> (ent_q[$past(cdb_tag_i)].done && ent_q[$past(cdb_tag_i)].val == $past(cdb_value_i)));
endmodule

// File: rtl/rob_retire.sv
module rob_retire
  import rob_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEST_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              head_valid_i,
  input  logic              head_done_i,
  input  logic              head_exc_i,
  input  logic              head_mis_i,
  input  rob_kind_e         head_kind_i,
  input  logic [DEST_W-1:0] head_dest_i,
  input  logic [DATA_W-1:0] head_val_i,
  output logic              commit_o,
  output logic              flush_o,
  output logic              exc_o,
  output logic              rf_we_o,
  output logic [DEST_W-1:0] rf_addr_o,
  output logic [DATA_W-1:0] rf_data_o,
  output logic              st_valid_o,
  output logic [DEST_W-1:0] st_addr_o,
  output logic [DATA_W-1:0] st_data_o
);
  logic go;

  assign go         = head_valid_i && head_done_i;
  assign commit_o   = go;
  assign exc_o      = go && head_exc_i;
  assign flush_o    = go && (head_exc_i || (head_kind_i == KIND_BRANCH && head_mis_i));
  assign rf_we_o    = go && !head_exc_i && head_kind_i == KIND_REG;
  assign st_valid_o = go && !head_exc_i && head_kind_i == KIND_STORE;
  assign rf_addr_o  = head_dest_i;
  assign rf_data_o  = head_val_i;
  assign st_addr_o  = head_dest_i;
  assign st_data_o  = head_val_i;

  p_one_port_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rf_we_o && st_valid_o));
endmodule

// File: rtl/spec_rob.sv
module spec_rob
  import rob_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int DATA_W = 32,
  parameter int DEST_W = 16,
  parameter int N_LOOK = 2,
  localparam int TAG_W = $clog2(DEPTH)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     issue_valid_i,
  input  logic [1:0]               issue_kind_i,
  input  logic [DEST_W-1:0]        issue_dest_i,
  output logic                     issue_ready_o,
  output logic [TAG_W-1:0]         issue_tag_o,
  input  logic                     cdb_valid_i,
  input  logic [TAG_W-1:0]         cdb_tag_i,
  input  logic [DATA_W-1:0]        cdb_value_i,
  input  logic                     cdb_exc_i,
  input  logic                     cdb_mispred_i,
  input  logic [N_LOOK*TAG_W-1:0]  lookup_tag_i,
  output logic [N_LOOK-1:0]        lookup_ready_o,
  output logic [N_LOOK*DATA_W-1:0] lookup_value_o,
  output logic                     rf_we_o,
  output logic [DEST_W-1:0]        rf_addr_o,
  output logic [DATA_W-1:0]        rf_data_o,
  output logic                     st_valid_o,
  output logic [DEST_W-1:0]        st_addr_o,
  output logic [DATA_W-1:0]        st_data_o,
  output logic                     exc_o,
  output logic                     flush_o
);
  logic              commit, alloc;
  logic [TAG_W-1:0]  head, tail;
  logic              h_valid, h_done, h_exc, h_mis;
  rob_kind_e         h_kind;
  logic [DEST_W-1:0] h_dest;
  logic [DATA_W-1:0] h_val;

  assign alloc       = issue_valid_i && issue_ready_o;
  assign issue_tag_o = tail;

  rob_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk_i, .rst_ni,
    .issue_valid_i,
    .commit_i   (commit),
    .flush_i    (flush_o),
    .issue_ok_o (issue_ready_o),
    .head_o     (head),
    .tail_o     (tail)
  );

  rob_entries #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .N_LOOK(N_LOOK)) u_ent (
    .clk_i, .rst_ni,
    .alloc_i       (alloc),
    .tail_i        (tail),
    .kind_i        (rob_kind_e'(issue_kind_i)),
    .dest_i        (issue_dest_i),
    .cdb_valid_i, .cdb_tag_i, .cdb_value_i, .cdb_exc_i, .cdb_mispred_i,
    .head_i        (head),
    .commit_i      (commit),
    .flush_i       (flush_o),
    .lookup_tag_i, .lookup_ready_o, .lookup_value_o,
    .head_valid_o  (h_valid),
    .head_done_o   (h_done),
    .head_exc_o    (h_exc),
    .head_mis_o    (h_mis),
    .head_kind_o   (h_kind),
    .head_dest_o   (h_dest),
    .head_val_o    (h_val)
  );

  rob_retire #(.DATA_W(DATA_W), .DEST_W(DEST_W)) u_ret (
    .clk_i, .rst_ni,
    .head_valid_i (h_valid),
    .head_done_i  (h_done),
    .head_exc_i   (h_exc),
    .head_mis_i   (h_mis),
    .head_kind_i  (h_kind),
    .head_dest_i  (h_dest),
    .head_val_i   (h_val),
    .commit_o     (commit),
    .flush_o, .exc_o, .rf_we_o, .rf_addr_o, .rf_data_o,
    .st_valid_o, .st_addr_o, .st_data_o
  );

  p_flush_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |=> !flush_o);
  p_exc_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_o |=> (!rf_we_o && !st_valid_o && !exc_o));
  p_flush_block_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_o |-> !issue_ready_o);
endmodule

// File: tb/spec_rob_tb.sv
module spec_rob_tb;
  localparam int DEPTH = 8, DATA_W = 32, DEST_W = 16, N_LOOK = 2, TAG_W = 3;

  logic clk = 0, rst_ni = 0;
  logic issue_valid_i = 0;
  logic [1:0] issue_kind_i = 0;
  logic [DEST_W-1:0] issue_dest_i = 0;
  logic issue_ready_o;
  logic [TAG_W-1:0] issue_tag_o;
  logic cdb_valid_i = 0, cdb_exc_i = 0, cdb_mispred_i = 0;
  logic [TAG_W-1:0] cdb_tag_i = 0;
  logic [DATA_W-1:0] cdb_value_i = 0;
  logic [TAG_W-1:0] lk0 = 0, lk1 = 0;
  logic [N_LOOK-1:0] lookup_ready_o;
  logic [N_LOOK*DATA_W-1:0] lookup_value_o;
  logic rf_we_o, st_valid_o, exc_o, flush_o;
  logic [DEST_W-1:0] rf_addr_o, st_addr_o;
  logic [DATA_W-1:0] rf_data_o, st_data_o;

  int n_chk = 0, n_fail = 0;
  int tag_exp;

  always #10 clk = ~clk;

  spec_rob #(.DEPTH(DEPTH), .DATA_W(DATA_W), .DEST_W(DEST_W), .N_LOOK(N_LOOK)) u_dut (
    .clk_i(clk), .rst_ni,
    .issue_valid_i, .issue_kind_i, .issue_dest_i, .issue_ready_o, .issue_tag_o,
    .cdb_valid_i, .cdb_tag_i, .cdb_value_i, .cdb_exc_i, .cdb_mispred_i,
    .lookup_tag_i({lk1, lk0}), .lookup_ready_o, .lookup_value_o,
    .rf_we_o, .rf_addr_o, .rf_data_o, .st_valid_o, .st_addr_o, .st_data_o,
    .exc_o, .flush_o
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  task automatic next();
    @(negedge clk);
    issue_valid_i = 0; cdb_valid_i = 0; cdb_exc_i = 0; cdb_mispred_i = 0;
  endtask

  task automatic issue(input logic [1:0] kind, input logic [DEST_W-1:0] dest);
    issue_valid_i = 1; issue_kind_i = kind; issue_dest_i = dest;
  endtask

  task automatic cdb(input logic [TAG_W-1:0] t, input logic [DATA_W-1:0] v,
                     input logic e, input logic m);
    cdb_valid_i = 1; cdb_tag_i = t; cdb_value_i = v; cdb_exc_i = e; cdb_mispred_i = m;
  endtask

  initial begin
    #(20 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1;
    #2;
    // R1 reset state
    chk("R1 ready", issue_ready_o, 1);
    chk("R1 tag", issue_tag_o, 0);
    chk("R1 quiet", {rf_we_o, st_valid_o, exc_o, flush_o, lookup_ready_o}, 0);

    // R2 fill
    for (int i = 0; i < DEPTH; i++) begin
      next(); issue(0, DEST_W'(100 + i)); #2;
      chk("R2 tag", issue_tag_o, i);
      chk("R2 ready", issue_ready_o, 1);
    end
    next(); #2;
    chk("R2 full", issue_ready_o, 0);

    // R3/R7 out-of-order completion with same-cycle lookup
    for (int t = DEPTH - 1; t >= 1; t--) begin
      next(); cdb(TAG_W'(t), 1000 + t, 0, 0); lk0 = TAG_W'(t); lk1 = 0; #2;
      chk("R4 no early commit", rf_we_o, 0);
      chk("R7 fwd ready", lookup_ready_o[0], 1);
      chk("R7 fwd value", lookup_value_o[0 +: DATA_W], 1000 + t);
      chk("R6 not done", lookup_ready_o[1], 0);
    end
    next(); lk0 = 5; #2;
    chk("R3 R6 stored ready", lookup_ready_o[0], 1);
    chk("R6 stored value", lookup_value_o[0 +: DATA_W], 1005);
    next(); cdb(0, 1000, 0, 0); #2;
    chk("R4 wait done", rf_we_o, 0);
    for (int i = 0; i < DEPTH; i++) begin
      next();
      if (i == 1) issue(0, 200);
      #2;
      chk("R4 we", rf_we_o, 1);
      chk("R4 addr", rf_addr_o, 100 + i);
      chk("R4 data", rf_data_o, 1000 + i);
      if (i == 0) chk("R2 full at commit", issue_ready_o, 0);
      if (i == 1) begin
        chk("R11 ready", issue_ready_o, 1);
        chk("R11 tag", issue_tag_o, 0);
      end
    end
    next(); #2;
    chk("R4 head pending", rf_we_o, 0);
    next(); cdb(0, 2000, 0, 0);
    next(); #2;
    chk("R11 late commit addr", rf_addr_o, 200);
    chk("R11 late commit data", {31'd0, rf_we_o, rf_data_o}, {32'd1, 32'd2000});

    // R5 store
    next(); issue(1, 55); #2;
    chk("R5 tag", issue_tag_o, 1);
    next(); cdb(1, 77, 0, 0);
    next(); #2;
    chk("R5 st valid", st_valid_o, 1);
    chk("R5 st addr", st_addr_o, 55);
    chk("R5 st data", st_data_o, 77);
    chk("R5 no rf", rf_we_o, 0);

    // R8 mispredicted branch
    next(); issue(0, 10); #2; chk("R8 tag a", issue_tag_o, 2);
    next(); issue(2, 0);  #2; chk("R8 tag br", issue_tag_o, 3);
    next(); issue(0, 11);
    next(); issue(0, 12);
    next(); cdb(4, 400, 0, 0);
    next(); cdb(5, 500, 0, 0);
    next(); cdb(2, 300, 0, 0); #2;
    chk("R4 head not done", rf_we_o, 0);
    next(); cdb(3, 0, 0, 1); #2;
    chk("R4 commit before br", {rf_we_o, flush_o}, 2'b10);
    chk("R4 data before br", rf_data_o, 300);
    next(); #2;
    chk("R8 flush", flush_o, 1);
    chk("R8 no write", {rf_we_o, st_valid_o, exc_o}, 0);
    chk("R10 blocked", issue_ready_o, 0);
    next(); lk0 = 4; #2;
    chk("R8 pulse", flush_o, 0);
    chk("R8 no younger commit", rf_we_o, 0);
    chk("R8 next tag", issue_tag_o, 4);
    chk("R8 R6 discarded", lookup_ready_o[0], 0);

    // R8 correctly predicted branch
    next(); issue(2, 0); #2;
    chk("R8 tag", issue_tag_o, 4);
    next(); cdb(4, 0, 0, 0);
    next(); #2;
    chk("R8 good branch", {flush_o, rf_we_o, st_valid_o}, 0);
    next(); #2;
    chk("R8 retired", issue_tag_o, 5);

    // R9 deferred exception
    next(); issue(0, 20);
    next(); issue(0, 21);
    next(); cdb(6, 66, 1, 0);
    next(); cdb(5, 11, 0, 0); #2;
    chk("R9 not at head", {exc_o, flush_o}, 0);
    next(); #2;
    chk("R9 older commits", {rf_we_o, exc_o}, 2'b10);
    chk("R9 older data", rf_data_o, 11);
    next(); #2;
    chk("R9 exc", {exc_o, flush_o}, 2'b11);
    chk("R9 no write", {rf_we_o, st_valid_o}, 0);
    next(); #2;
    chk("R9 after", {exc_o, flush_o, rf_we_o}, 0);
    chk("R9 tag", issue_tag_o, 7);

    // R2/R4 wrap sweep
    tag_exp = 7;
    for (int r = 0; r < 40; r++) begin
      next(); issue(0, DEST_W'(r)); #2;
      chk("R2 sweep tag", issue_tag_o, tag_exp);
      next(); cdb(TAG_W'(tag_exp), r * 3 + 1, 0, 0);
      next(); #2;
      chk("R4 sweep we", rf_we_o, 1);
      chk("R4 sweep addr", rf_addr_o, r);
      chk("R4 sweep data", rf_data_o, r * 3 + 1);
      tag_exp = (tag_exp + 1) % DEPTH;
    end
    summary();
  end
endmodule